// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block translates a virtual address to a physical address for the address space that is currently running. It holds a small set of translations, and every stored translation is compared against the incoming virtual page number in the same cycle. A translation matches only if its stored page tag and its stored address-space identifier both equal the lookup page and the current identifier. After a match the block checks the caller's privilege level and the access type against the page's permission fields. It reports exactly one of hit, miss or protection fault. On a hit it returns the physical address. The 12-bit page offset passes through unchanged.

The block does not walk page tables. A miss goes back to software. A kernel-mode handler then installs the missing translation through a write port, either into an explicit slot or into the slot named by a free-running pseudo-random index. The handler also changes the current address-space identifier through its own write strobe. Both kinds of write are refused outside kernel mode, and a refused write raises a privilege fault.

Top module: `asid_tlb`

## Requirements
- R1: A lookup matching a valid slot's page tag and ASID, with access permitted, asserts `lk_hit` and returns `lk_paddr` = {slot frame, low 12 bits of `lk_vaddr`}.
- R2: A slot whose ASID differs from `cur_asid` never matches; such a lookup reports `lk_miss` when no other slot matches.
- R3: A slot written with its valid bit 0 never matches.
- R4: Mode codes are 0 kernel, 1 supervisor and 2 user. Access is allowed only when `cur_mode` is numerically no greater than the slot's mode field. A matching lookup that is not allowed asserts `lk_fault` and not `lk_hit`.
- R5: A store (`lk_store`=1) to a matching slot whose writable bit is 0 asserts `lk_fault` in every mode. A load to the same slot can still hit.
- R6: `lk_hit`, `lk_miss` and `lk_fault` are combinational and never more than one is high. All three are 0 while `lk_valid` is 0.
- R7: A kernel-mode write with `wr_random`=0 replaces the content of slot `wr_index`. The new content is visible to lookups from the next cycle.
- R8: A kernel-mode write with `wr_random`=1 goes to the slot shown on `rand_idx` in the cycle of the write.
- R9: `rand_idx` reads ENTRIES-1 after reset. It changes every cycle and takes all ENTRIES values in any ENTRIES consecutive cycles.
- R10: A slot write or an ASID write while `cur_mode` is not 0 has no effect, and `priv_fault` is high in that cycle.
- R11: After reset every slot is invalid and `cur_asid` is 0.
- R12: A kernel-mode `asid_we` loads `asid_wdata` into `cur_asid` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cur_mode | input | 2 | Current privilege: 0 kernel, 1 supervisor, 2 user |
| lk_valid | input | 1 | Lookup request |
| lk_store | input | 1 | Lookup is a store |
| lk_vaddr | input | VA_W | Virtual address to translate |
| lk_hit | output | 1 | Translation found and allowed |
| lk_miss | output | 1 | No slot matches |
| lk_fault | output | 1 | Slot matches but access is refused |
| lk_paddr | output | PA_W | Translated address, 0 unless hit |
| asid_we | input | 1 | Load a new current ASID |
| asid_wdata | input | ASID_W | New ASID value |
| cur_asid | output | ASID_W | Current address-space identifier |
| wr_en | input | 1 | Install a slot |
| wr_random | input | 1 | 1: slot from `rand_idx`, 0: slot from `wr_index` |
| wr_index | input | IDX_W | Explicit slot number |
| wr_vpn | input | VA_W-12 | Page tag to store |
| wr_asid | input | ASID_W | ASID to store |
| wr_pfn | input | PA_W-12 | Physical frame to store |
| wr_valid | input | 1 | Valid bit to store |
| wr_mode | input | 2 | Least-privileged mode allowed to access the page |
| wr_writable | input | 1 | Stores allowed |
| rand_idx | output | IDX_W | Current pseudo-random victim slot |
| priv_fault | output | 1 | Write refused because the mode is not kernel |

## Verification
The random-slot refill is the hardest case to reach from the ports, because which slot it lands in cannot be seen from a lookup. The bench reads `rand_idx` just before the write edge. It installs a unique tag there, then overwrites that same slot number explicitly. The first tag must then miss and the second must hit, which ties the random write to the slot that was shown. A second hard case is one page tag held under two ASIDs. It is exercised by switching the current ASID between lookups of the same address.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

   typedef enum logic [1:0] {
      MODE_KERN = 2'd0,
      MODE_SUPV = 2'd1,
      MODE_USER = 2'd2
   } mode_e;

   // Lower code is more privileged; a page admits its own mode and any more privileged one.
   function automatic logic mode_reaches(input logic [1:0] cur, input logic [1:0] page_mode);
      return cur <= page_mode;
   endfunction

   // Feedback tap masks for maximal shift registers, shift-left form, MSB leaves.
   function automatic logic [5:0] tap_mask(input int w);
      case (w)
         2:       return 6'b000011;
         3:       return 6'b000110;
         4:       return 6'b001100;
         5:       return 6'b010100;
         default: return 6'b110000;
      endcase
   endfunction

endpackage

// File: rtl/tlb_victim_gen.sv
module tlb_victim_gen #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   output logic [W-1:0] idx
);
   localparam logic [5:0] MASK6 = tlb_pkg::tap_mask(W);
   localparam logic [W-1:0] TAPS = MASK6[W-1:0];

   generate
      if (W < 2 || W > 6) begin : g_bad_w
         $error("tlb_victim_gen: W must lie in 2..6");
      end
   endgenerate

   logic [W-1:0] state_q;
   logic         fb;

   // Zero-insertion term stretches the 2^W-1 cycle to the full 2^W.
   always_comb begin
      fb = (^(state_q & TAPS)) ^ (state_q[W-2:0] == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= '1;
      else        state_q <= {state_q[W-2:0], fb};
   end

   assign idx = state_q;

   property p_step;
      @(posedge clk) disable iff (!rst_n) $past(rst_n) |-> (state_q != $past(state_q));
   endproperty
   assert_idx_moves_R9: assert property (p_step);

endmodule

// File: rtl/tlb_slot_store.sv
module tlb_slot_store #(
   parameter int ENTRIES = 16,
   parameter int VPN_W   = 20,
   parameter int PFN_W   = 20,
   parameter int ASID_W  = 8,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            we,
   input  logic [IDX_W-1:0]                widx,
   input  logic [VPN_W-1:0]                wvpn,
   input  logic [ASID_W-1:0]               wasid,
   input  logic [PFN_W-1:0]                wpfn,
   input  logic                            wvalid,
   input  logic [1:0]                      wmode,
   input  logic                            wwritable,
   output logic [ENTRIES-1:0]              s_valid,
   output logic [ENTRIES-1:0][VPN_W-1:0]   s_vpn,
   output logic [ENTRIES-1:0][ASID_W-1:0]  s_asid,
   output logic [ENTRIES-1:0][PFN_W-1:0]   s_pfn,
   output logic [ENTRIES-1:0][1:0]         s_mode,
   output logic [ENTRIES-1:0]              s_writable
);
   generate
      for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               s_valid[i]    <= 1'b0;
               s_vpn[i]      <= '0;
               s_asid[i]     <= '0;
               s_pfn[i]      <= '0;
               s_mode[i]     <= 2'd0;
               s_writable[i] <= 1'b0;
            end else if (we && widx == IDX_W'(i)) begin
               s_valid[i]    <= wvalid;
               s_vpn[i]      <= wvpn;
               s_asid[i]     <= wasid;
               s_pfn[i]      <= wpfn;
               s_mode[i]     <= wmode;
               s_writable[i] <= wwritable;
            end
         end
      end
   endgenerate

   property p_untouched;
      @(posedge clk) disable iff (!rst_n) !we |=> $stable(s_valid);
   endproperty
   assert_quiet_slots_R7: assert property (p_untouched);

endmodule

// File: rtl/tlb_lookup.sv
module tlb_lookup #(
   parameter int ENTRIES = 16,
   parameter int VPN_W   = 20,
   parameter int PFN_W   = 20,
   parameter int ASID_W  = 8
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            lk_valid,
   input  logic                            lk_store,
   input  logic [VPN_W-1:0]                lk_vpn,
   input  logic [ASID_W-1:0]               asid,
   input  logic [1:0]                      mode,
   input  logic [ENTRIES-1:0]              s_valid,
   input  logic [ENTRIES-1:0][VPN_W-1:0]   s_vpn,
   input  logic [ENTRIES-1:0][ASID_W-1:0]  s_asid,
   input  logic [ENTRIES-1:0][PFN_W-1:0]   s_pfn,
   input  logic [ENTRIES-1:0][1:0]         s_mode,
   input  logic [ENTRIES-1:0]              s_writable,
   output logic                            hit,
   output logic                            miss,
   output logic                            fault,
   output logic [PFN_W-1:0]                pfn
);
   logic [ENTRIES-1:0] tag_eq;

   generate
      for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
         assign tag_eq[i] = s_valid[i] && (s_vpn[i] == lk_vpn) && (s_asid[i] == asid);
      end
   endgenerate

   logic             any_eq;
   logic [PFN_W-1:0] sel_pfn;
   logic [1:0]       sel_mode;
   logic             sel_wr;

   // Lowest-numbered matching slot wins if software left duplicates.
   always_comb begin
      any_eq   = 1'b0;
      sel_pfn  = '0;
      sel_mode = 2'd0;
      sel_wr   = 1'b0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (tag_eq[i]) begin
            any_eq   = 1'b1;
            sel_pfn  = s_pfn[i];
            sel_mode = s_mode[i];
            sel_wr   = s_writable[i];
         end
      end
   end

   logic allowed;
   always_comb begin
      allowed = tlb_pkg::mode_reaches(mode, sel_mode) && (!lk_store || sel_wr);
      hit     = lk_valid &&  any_eq &&  allowed;
      fault   = lk_valid &&  any_eq && !allowed;
      miss    = lk_valid && !any_eq;
      pfn     = hit ? sel_pfn : '0;
   end

   property p_excl;
      @(posedge clk) disable iff (!rst_n) $onehot0({hit, miss, fault});
   endproperty
   assert_one_outcome_R6: assert property (p_excl);

   property p_idle;
      @(posedge clk) disable iff (!rst_n) !lk_valid |-> !(hit || miss || fault);
   endproperty
   assert_idle_quiet_R6: assert property (p_idle);

   property p_no_dead_hit;
      @(posedge clk) disable iff (!rst_n) (s_valid == '0) |-> !hit;
   endproperty
   assert_empty_no_hit_R3: assert property (p_no_dead_hit);

endmodule

// File: rtl/asid_tlb.sv
module asid_tlb #(
   parameter int ENTRIES   = 16,
   parameter int VA_W      = 32,
   parameter int PA_W      = 32,
   parameter int PAGE_BITS = 12,
   parameter int ASID_W    = 8,
   localparam int IDX_W    = $clog2(ENTRIES),
   localparam int VPN_W    = VA_W - PAGE_BITS,
   localparam int PFN_W    = PA_W - PAGE_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cur_mode,
   input  logic              lk_valid,
   input  logic              lk_store,
   input  logic [VA_W-1:0]   lk_vaddr,
   output logic              lk_hit,
   output logic              lk_miss,
   output logic              lk_fault,
   output logic [PA_W-1:0]   lk_paddr,
   input  logic              asid_we,
   input  logic [ASID_W-1:0] asid_wdata,
   output logic [ASID_W-1:0] cur_asid,
   input  logic              wr_en,
   input  logic              wr_random,
   input  logic [IDX_W-1:0]  wr_index,
   input  logic [VPN_W-1:0]  wr_vpn,
   input  logic [ASID_W-1:0] wr_asid,
   input  logic [PFN_W-1:0]  wr_pfn,
   input  logic              wr_valid,
   input  logic [1:0]        wr_mode,
   input  logic              wr_writable,
   output logic [IDX_W-1:0]  rand_idx,
   output logic              priv_fault
);
   import tlb_pkg::*;

   generate
      if ((1 << IDX_W) != ENTRIES || IDX_W < 2 || IDX_W > 6) begin : g_bad_entries
         $error("asid_tlb: ENTRIES must be a power of two from 4 to 64");
      end
      if (VA_W <= PAGE_BITS || PA_W <= PAGE_BITS) begin : g_bad_width
         $error("asid_tlb: address widths must exceed the page offset");
      end
   endgenerate

   logic is_kern;
   assign is_kern    = (cur_mode == MODE_KERN);
   assign priv_fault = (wr_en || asid_we) && !is_kern;

   // Current address space.
   logic [ASID_W-1:0] asid_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 asid_q <= '0;
      else if (asid_we && is_kern) asid_q <= asid_wdata;
   end
   assign cur_asid = asid_q;

   // Victim index.
   logic [IDX_W-1:0] victim;
   tlb_victim_gen #(.W(IDX_W)) u_victim (
      .clk   (clk),
      .rst_n (rst_n),
      .idx   (victim)
   );
   assign rand_idx = victim;

   // Slot storage.
   logic                           st_we;
   logic [IDX_W-1:0]               st_idx;
   logic [ENTRIES-1:0]             s_valid;
   logic [ENTRIES-1:0][VPN_W-1:0]  s_vpn;
   logic [ENTRIES-1:0][ASID_W-1:0] s_asid;
   logic [ENTRIES-1:0][PFN_W-1:0]  s_pfn;
   logic [ENTRIES-1:0][1:0]        s_mode;
   logic [ENTRIES-1:0]             s_writable;

   assign st_we  = wr_en && is_kern;
   assign st_idx = wr_random ? victim : wr_index;

   tlb_slot_store #(
      .ENTRIES (ENTRIES),
      .VPN_W   (VPN_W),
      .PFN_W   (PFN_W),
      .ASID_W  (ASID_W)
   ) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .we         (st_we),
      .widx       (st_idx),
      .wvpn       (wr_vpn),
      .wasid      (wr_asid),
      .wpfn       (wr_pfn),
      .wvalid     (wr_valid),
      .wmode      (wr_mode),
      .wwritable  (wr_writable),
      .s_valid    (s_valid),
      .s_vpn      (s_vpn),
      .s_asid     (s_asid),
      .s_pfn      (s_pfn),
      .s_mode     (s_mode),
      .s_writable (s_writable)
   );

   // Parallel compare and permission check.
   logic [PFN_W-1:0] hit_pfn;
   tlb_lookup #(
      .ENTRIES (ENTRIES),
      .VPN_W   (VPN_W),
      .PFN_W   (PFN_W),
      .ASID_W  (ASID_W)
   ) u_lookup (
      .clk        (clk),
      .rst_n      (rst_n),
      .lk_valid   (lk_valid),
      .lk_store   (lk_store),
      .lk_vpn     (lk_vaddr[VA_W-1:PAGE_BITS]),
      .asid       (asid_q),
      .mode       (cur_mode),
      .s_valid    (s_valid),
      .s_vpn      (s_vpn),
      .s_asid     (s_asid),
      .s_pfn      (s_pfn),
      .s_mode     (s_mode),
      .s_writable (s_writable),
      .hit        (lk_hit),
      .miss       (lk_miss),
      .fault      (lk_fault),
      .pfn        (hit_pfn)
   );

   assign lk_paddr = lk_hit ? {hit_pfn, lk_vaddr[PAGE_BITS-1:0]} : '0;

   property p_asid_guard;
      @(posedge clk) disable iff (!rst_n) (asid_we && cur_mode != MODE_KERN) |=> $stable(cur_asid);
   endproperty
   assert_asid_guard_R10: assert property (p_asid_guard);

   property p_slot_guard;
      @(posedge clk) disable iff (!rst_n) (wr_en && cur_mode != MODE_KERN) |=> $stable(s_valid);
   endproperty
   assert_slot_guard_R10: assert property (p_slot_guard);

   property p_asid_load;
      @(posedge clk) disable iff (!rst_n) (asid_we && cur_mode == MODE_KERN) |=> (cur_asid == $past(asid_wdata));
   endproperty
   assert_asid_load_R12: assert property (p_asid_load);

   property p_miss_addr;
      @(posedge clk) disable iff (!rst_n) !lk_hit |-> (lk_paddr == '0);
   endproperty
   assert_paddr_only_on_hit_R1: assert property (p_miss_addr);

endmodule

// File: tb/sim_asid_tlb.sv
module sim_asid_tlb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic [1:0]  cur_mode = 2'd0;
   logic        lk_valid = 1'b0, lk_store = 1'b0;
   logic [31:0] lk_vaddr = '0;
   logic        lk_hit, lk_miss, lk_fault;
   logic [31:0] lk_paddr;
   logic        asid_we = 1'b0;
   logic [7:0]  asid_wdata = '0, cur_asid;
   logic        wr_en = 1'b0, wr_random = 1'b0;
   logic [3:0]  wr_index = '0, rand_idx;
   logic [19:0] wr_vpn = '0, wr_pfn = '0;
   logic [7:0]  wr_asid = '0;
   logic        wr_valid = 1'b0, wr_writable = 1'b0;
   logic [1:0]  wr_mode = 2'd0;
   logic        priv_fault;

   asid_tlb u0 (.*);

   int total = 0, bad = 0;

   task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic install(input logic [3:0] idx, input logic [19:0] vpn, input logic [7:0] asid,
                          input logic [19:0] pfn, input logic v, input logic [1:0] md, input logic w);
      @(negedge clk);
      wr_en = 1'b1; wr_random = 1'b0; wr_index = idx; wr_vpn = vpn; wr_asid = asid;
      wr_pfn = pfn; wr_valid = v; wr_mode = md; wr_writable = w;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic set_asid(input logic [7:0] a);
      @(negedge clk);
      asid_we = 1'b1; asid_wdata = a;
      @(negedge clk);
      asid_we = 1'b0;
   endtask

   // Drive a lookup at a falling edge, return {hit,miss,fault} and paddr after settling.
   task automatic look(input logic [1:0] md, input logic st, input logic [31:0] va,
                       output logic [2:0] hmf, output logic [31:0] pa);
      @(negedge clk);
      cur_mode = md; lk_valid = 1'b1; lk_store = st; lk_vaddr = va;
      #1;
      hmf = {lk_hit, lk_miss, lk_fault};
      pa  = lk_paddr;
      lk_valid = 1'b0; lk_store = 1'b0; cur_mode = 2'd0;
   endtask

   typedef struct packed {
      logic [1:0]  md;
      logic        st;
      logic [31:0] va;
      logic [2:0]  hmf;
      logic [31:0] pa;
   } vec_t;

   // hmf: 100 hit, 010 miss, 001 fault.  Current ASID is 5.
   localparam vec_t VTAB [11] = '{
      '{2'd2, 1'b0, 32'h0001_2345, 3'b100, 32'hABCD_E345},  // R1
      '{2'd2, 1'b1, 32'h0001_2FFF, 3'b100, 32'hABCD_EFFF},  // R1
      '{2'd2, 1'b0, 32'h0003_4010, 3'b001, 32'h0},          // R4 user on kernel page
      '{2'd0, 1'b0, 32'h0003_4010, 3'b100, 32'h1111_1010},  // R4
      '{2'd1, 1'b0, 32'h0005_6000, 3'b100, 32'h2222_2000},  // R4
      '{2'd2, 1'b0, 32'h0005_6000, 3'b001, 32'h0},          // R4 user on supervisor page
      '{2'd2, 1'b0, 32'h0007_8ABC, 3'b100, 32'h3333_3ABC},  // R5 load on read-only
      '{2'd2, 1'b1, 32'h0007_8ABC, 3'b001, 32'h0},          // R5
      '{2'd0, 1'b1, 32'h0007_8ABC, 3'b001, 32'h0},          // R5 kernel too
      '{2'd0, 1'b0, 32'h0009_A000, 3'b010, 32'h0},          // R3 invalid slot
      '{2'd2, 1'b0, 32'h000B_C000, 3'b010, 32'h0}           // R2 no slot
   };

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      logic [2:0]  hmf;
      logic [31:0] pa;
      logic [3:0]  r;
      logic [15:0] seen;
      logic [3:0]  prev;

      repeat (3) @(negedge clk);
      #1;
      check(cur_asid == 8'd0, "R11 asid after reset", cur_asid, 0);
      check(rand_idx == 4'hF, "R9 victim after reset", rand_idx, 4'hF);
      check(priv_fault == 1'b0, "R10 no fault idle", priv_fault, 0);
      rst_n = 1'b1;
      look(2'd0, 1'b0, 32'h0000_0000, hmf, pa);
      check(hmf == 3'b010, "R11 empty table misses", hmf, 3'b010);

      install(4'd0, 20'h00012, 8'd5, 20'hABCDE, 1'b1, 2'd2, 1'b1);
      install(4'd1, 20'h00034, 8'd5, 20'h11111, 1'b1, 2'd0, 1'b1);
      install(4'd2, 20'h00056, 8'd5, 20'h22222, 1'b1, 2'd1, 1'b1);
      install(4'd3, 20'h00078, 8'd5, 20'h33333, 1'b1, 2'd2, 1'b0);
      install(4'd4, 20'h0009A, 8'd5, 20'h44444, 1'b0, 2'd2, 1'b1);
      install(4'd5, 20'h00012, 8'd6, 20'h55555, 1'b1, 2'd2, 1'b1);
      set_asid(8'd5);
      #1;
      check(cur_asid == 8'd5, "R12 asid loaded", cur_asid, 5);

      for (int i = 0; i < 11; i++) begin
         look(VTAB[i].md, VTAB[i].st, VTAB[i].va, hmf, pa);
         check(hmf == VTAB[i].hmf, $sformatf("R1/R4/R5/R7 vec%0d outcome", i), hmf, VTAB[i].hmf);
         check(pa == VTAB[i].pa, $sformatf("R1 vec%0d paddr", i), pa, VTAB[i].pa);
      end

      // R6: idle lookup port drives nothing.
      @(negedge clk);
      lk_valid = 1'b0; lk_vaddr = 32'h0001_2345;
      #1;
      check({lk_hit, lk_miss, lk_fault} == 3'b000, "R6 idle outputs", {lk_hit, lk_miss, lk_fault}, 0);

      // R2: same page under another ASID.
      set_asid(8'd6);
      look(2'd2, 1'b0, 32'h0001_2345, hmf, pa);
      check(hmf == 3'b100 && pa == 32'h5555_5345, "R2 asid 6 selects its own slot", pa, 32'h5555_5345);
      set_asid(8'd7);
      look(2'd2, 1'b0, 32'h0001_2345, hmf, pa);
      check(hmf == 3'b010, "R2 foreign asid misses", hmf, 3'b010);

      // R10: user-mode ASID and slot writes are refused.
      @(negedge clk);
      cur_mode = 2'd2; asid_we = 1'b1; asid_wdata = 8'd6;
      #1;
      check(priv_fault == 1'b1, "R10 fault on user asid write", priv_fault, 1);
      @(negedge clk);
      asid_we = 1'b0; cur_mode = 2'd0;
      #1;
      check(cur_asid == 8'd7, "R10 asid unchanged", cur_asid, 7);
      @(negedge clk);
      cur_mode = 2'd1; wr_en = 1'b1; wr_random = 1'b0; wr_index = 4'd6;
      wr_vpn = 20'h000CC; wr_asid = 8'd7; wr_pfn = 20'h66666; wr_valid = 1'b1; wr_mode = 2'd2; wr_writable = 1'b1;
      #1;
      check(priv_fault == 1'b1, "R10 fault on supervisor slot write", priv_fault, 1);
      @(negedge clk);
      wr_en = 1'b0; cur_mode = 2'd0;
      look(2'd0, 1'b0, 32'h000C_C000, hmf, pa);
      check(hmf == 3'b010, "R10 slot write ignored", hmf, 3'b010);

      // R8: random refill lands in the slot shown, proven by overwriting that slot.
      @(negedge clk);
      r = rand_idx;
      wr_en = 1'b1; wr_random = 1'b1; wr_vpn = 20'h0ABC0; wr_asid = 8'd7;
      wr_pfn = 20'h77777; wr_valid = 1'b1; wr_mode = 2'd2; wr_writable = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; wr_random = 1'b0;
      look(2'd2, 1'b0, 32'h0ABC_0123, hmf, pa);
      check(hmf == 3'b100 && pa == 32'h7777_7123, "R8 random refill hits", pa, 32'h7777_7123);
      install(r, 20'h0DEF0, 8'd7, 20'h88888, 1'b1, 2'd2, 1'b1);
      look(2'd2, 1'b0, 32'h0ABC_0123, hmf, pa);
      check(hmf == 3'b010, "R8 R7 overwrite of shown slot evicts", hmf, 3'b010);
      look(2'd2, 1'b0, 32'h0DEF_0004, hmf, pa);
      check(hmf == 3'b100 && pa == 32'h8888_8004, "R7 overwritten slot hits", pa, 32'h8888_8004);

      // R9: full period, changes every cycle.
      @(negedge clk);
      seen = '0;
      prev = rand_idx;
      seen[rand_idx] = 1'b1;
      for (int k = 1; k < 16; k++) begin
         @(negedge clk);
         check(rand_idx != prev, "R9 victim moves each cycle", rand_idx, prev);
         prev = rand_idx;
         seen[rand_idx] = 1'b1;
      end
      check(seen == 16'hFFFF, "R9 all slots visited", seen, 16'hFFFF);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule